// File: doc/BRIEF.md
# Privilege-Gated Interrupt Controller Register Window

This block is the memory-mapped register window of a vectored interrupt controller. It holds per-interrupt enable and pending bits and an 8-bit priority for each external interrupt. It also holds twelve system-handler priority bytes, a control register with a user-trigger grant bit, and a software trigger register that sets an interrupt pending. Active status comes in from the exception-entry logic and can only be read here. Enable, pending and priority state go out on flat vectors to that logic.

Every request carries an unprivileged attribute. An unprivileged access gets an error response and has no effect, at every offset except the software trigger, which user code may access only while the grant bit is set. The error is only reported; fault handling belongs to the core.

The block runs one access at a time through three named states. IDLE accepts a request (transition ACCEPT to EXEC). EXEC decodes the request, checks privilege, applies any write and registers the response (transition APPLY to RESP). RESP presents the response for one cycle (transition RETIRE to IDLE).

Top module: `irq_regwin`

## Requirements
- R1: An access with `req_user`=1 to any offset other than the trigger register 0xF00 completes with `rsp_err`=1 and `rsp_rdata`=0. It changes no enable, pending, priority or control state.
- R2: The control register at 0xD14 is read/write, word-sized, privileged-only, and holds the user-trigger grant in bit 1; all other bits read 0. An unprivileged access to 0xF00 returns error while that bit is 0 and OK while it is 1. An unprivileged read of 0xF00 returns 0.
- R3: A word write to 0xF00 takes n = wdata[8:0]. It sets pending bit n when n < NUM_IRQ and is otherwise ignored; wdata bits above 8 are ignored.
- R4: Enable words: 0x100–0x13F set and 0x180–0x1BF clear. Word w = addr[5:2] covers interrupts 32w to 32w+31, LSB first. A read of either view returns the enable bits. A written 1 sets the bit (set view) or clears it (clear view), and a 0 leaves it unchanged.
- R5: Pending words use the same layout: set at 0x200–0x23F and clear at 0x280–0x2BF. Reads return pending bits.
- R6: Active words at 0x300–0x33F read the `active_in` bits in the same layout. Writes there return OK and change nothing.
- R7: Priority bytes at 0x400–0x5EF: byte offset d is interrupt d. An access of N bytes covers interrupts d..d+N−1, where data byte lane i holds interrupt d+i, for both reads and writes; lanes not covered read 0.
- R8: Handler priority bytes at 0xD18–0xD23: lane i of an access at offset a maps to handler index (a − 0xD14) + i. Indices 4..15 are held and come out on `sys_prio` byte (index − 4); lanes whose index falls outside that range read 0 and are not written.
- R9: Size codes: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = no bytes. A write of any size other than 4 to a word register (enable, pending, active, control, trigger) changes nothing and returns OK. Reads of word registers return the whole word for any size.
- R10: Privileged accesses to unmapped offsets read 0, ignore writes and return OK. Bits and bytes for interrupts at or above NUM_IRQ read 0 and ignore writes.
- R11: A request accepted at a clock edge (while `req_ready`=1) gives `rsp_valid`=1 for exactly one cycle, starting at the second following edge. This latency is the same for faulting accesses. `req_ready` is low from acceptance until the response retires, and `rsp_rdata` is 0 for writes.
- R12: After reset all enable, pending, priority, handler-priority and control state is 0, `req_ready`=1 and `rsp_valid`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request (IDLE) |
| req_addr | input | 12 | Byte offset within the window |
| req_size | input | 2 | Size code: 0=1, 1=2, 2=4 bytes, 3=none |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data, byte lane i in bits 8i+7..8i |
| req_user | input | 1 | Unprivileged attribute |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_err | output | 1 | Error response |
| rsp_rdata | output | 32 | Read data |
| active_in | input | NUM_IRQ | Active status from exception-entry logic |
| irq_enable | output | NUM_IRQ | Enable bits |
| irq_pending | output | NUM_IRQ | Pending bits |
| irq_prio | output | 8*NUM_IRQ | Priority byte k at bits 8k+7..8k |
| sys_prio | output | 96 | Handler priority for index 4+j at bits 8j+7..8j |

## Verification
Within a single write, the byte-lane update and the out-of-range discard run side by side. A four-byte priority write at 0x43C with NUM_IRQ=62 updates interrupts 60 and 61 and drops lanes 2 and 3 in the same EXEC cycle. The same happens at 0xD22, where lanes 2 and 3 fall past the last handler byte. A readback must show the kept bytes updated and the dropped lanes reading 0. The privilege check and the trigger write also meet in the same EXEC cycle. An unprivileged write to 0xF00 is issued with the grant bit clear and then with it set. Each is judged by its response code and by a readback of the pending word.

// File: rtl/irq_regwin_pkg.sv
package irq_regwin_pkg;
    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 32;
    localparam int LANES   = DATA_W / 8;
    localparam int SYS_N   = 12;
    localparam int START_W = 10;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EXEC,
        ST_RESP
    } state_e;

    typedef enum logic [3:0] {
        RG_NONE,
        RG_SETEN,
        RG_CLREN,
        RG_SETPD,
        RG_CLRPD,
        RG_ACTIVE,
        RG_PRIO,
        RG_SYSPRIO,
        RG_CTRL,
        RG_TRIG
    } region_e;

    function automatic logic [2:0] size_bytes(input logic [1:0] code);
        case (code)
            2'b00:   return 3'd1;
            2'b01:   return 3'd2;
            2'b10:   return 3'd4;
            default: return 3'd0;
        endcase
    endfunction
endpackage

// File: rtl/irq_regwin_decode.sv
module irq_regwin_decode
    import irq_regwin_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              user,
    input  logic              user_trig_en,
    output region_e           region,
    output logic              fault
);
    localparam logic [ADDR_W-1:0] A_PRIO_LO = ADDR_W'(12'h400);
    localparam logic [ADDR_W-1:0] A_PRIO_HI = ADDR_W'(12'h5EF);
    localparam logic [ADDR_W-1:0] A_SYS_LO  = ADDR_W'(12'hD18);
    localparam logic [ADDR_W-1:0] A_SYS_HI  = ADDR_W'(12'hD23);
    localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(12'hD14);
    localparam logic [ADDR_W-1:0] A_TRIG    = ADDR_W'(12'hF00);

    always_comb begin
        region = RG_NONE;
        if (addr[ADDR_W-1:6] == 6'h04)                   region = RG_SETEN;
        else if (addr[ADDR_W-1:6] == 6'h06)              region = RG_CLREN;
        else if (addr[ADDR_W-1:6] == 6'h08)              region = RG_SETPD;
        else if (addr[ADDR_W-1:6] == 6'h0A)              region = RG_CLRPD;
        else if (addr[ADDR_W-1:6] == 6'h0C)              region = RG_ACTIVE;
        else if (addr >= A_PRIO_LO && addr <= A_PRIO_HI) region = RG_PRIO;
        else if (addr >= A_SYS_LO && addr <= A_SYS_HI)   region = RG_SYSPRIO;
        else if (addr == A_CTRL)                         region = RG_CTRL;
        else if (addr == A_TRIG)                         region = RG_TRIG;
    end

    // Only the trigger register may admit user code, and only when granted.
    assign fault = user && !((region == RG_TRIG) && user_trig_en);
endmodule

// File: rtl/irq_regwin_prio_bank.sv
module irq_regwin_prio_bank
    import irq_regwin_pkg::*;
#(
    parameter int N = 62
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [START_W-1:0] start,
    input  logic [2:0]         nbytes,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic [N*8-1:0]     prio_flat
);
    logic [7:0] prio_q [N];

    for (genvar k = 0; k < N; k++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prio_q[k] <= '0;
            end else if (we) begin
                for (int i = 0; i < LANES; i++) begin
                    if (i < int'(nbytes) && int'(start) + i == k)
                        prio_q[k] <= wdata[8*i +: 8];
                end
            end
        end
        assign prio_flat[8*k +: 8] = prio_q[k];
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < LANES; i++) begin
            for (int k = 0; k < N; k++) begin
                if (i < int'(nbytes) && int'(start) + i == k)
                    rdata[8*i +: 8] = prio_q[k];
            end
        end
    end

    AST_PRIO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(prio_flat)); // R7
endmodule

// File: rtl/irq_regwin.sv
module irq_regwin
    import irq_regwin_pkg::*;
#(
    parameter int NUM_IRQ = 62
)(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [11:0]           req_addr,
    input  logic [1:0]            req_size,
    input  logic                  req_write,
    input  logic [31:0]           req_wdata,
    input  logic                  req_user,
    output logic                  rsp_valid,
    output logic                  rsp_err,
    output logic [31:0]           rsp_rdata,
    input  logic [NUM_IRQ-1:0]    active_in,
    output logic [NUM_IRQ-1:0]    irq_enable,
    output logic [NUM_IRQ-1:0]    irq_pending,
    output logic [NUM_IRQ*8-1:0]  irq_prio,
    output logic [SYS_N*8-1:0]    sys_prio
);
    localparam logic [ADDR_W-1:0] PRIO_BASE = ADDR_W'(12'h400);
    localparam logic [ADDR_W-1:0] SYS_BASE  = ADDR_W'(12'hD18);
    localparam logic [ADDR_W-1:0] TRIG_ADDR = ADDR_W'(12'hF00);

    state_e              state_q, state_d;
    logic [ADDR_W-1:0]   addr_q;
    logic [1:0]          size_q;
    logic                write_q, user_q;
    logic [DATA_W-1:0]   wdata_q;
    logic [NUM_IRQ-1:0]  en_q, en_d, pend_q, pend_d;
    logic                ctrl_trig_q, ctrl_trig_d;
    logic [DATA_W-1:0]   rdata_q, rdata_d;
    logic                err_q, err_d;

    region_e             region;
    logic                fault;
    logic                in_exec, word_wr;
    logic [2:0]          nbytes;
    logic [3:0]          widx;
    logic [NUM_IRQ-1:0]  wmask;
    logic [ADDR_W-1:0]   prio_off, sys_off;
    logic                prio_we, sys_we;
    logic [DATA_W-1:0]   prio_rd, sys_rd;

    function automatic logic [DATA_W-1:0] pick_word(input logic [NUM_IRQ-1:0] v,
                                                    input logic [3:0] w);
        logic [DATA_W-1:0] r;
        r = '0;
        for (int k = 0; k < NUM_IRQ; k++)
            if ((k / 32) == int'(w)) r[k % 32] = v[k];
        return r;
    endfunction

    function automatic logic [NUM_IRQ-1:0] spread_word(input logic [DATA_W-1:0] d,
                                                       input logic [3:0] w);
        logic [NUM_IRQ-1:0] m;
        m = '0;
        for (int k = 0; k < NUM_IRQ; k++)
            if ((k / 32) == int'(w)) m[k] = d[k % 32];
        return m;
    endfunction

    irq_regwin_decode u_decode (
        .addr         (addr_q),
        .user         (user_q),
        .user_trig_en (ctrl_trig_q),
        .region       (region),
        .fault        (fault)
    );

    assign in_exec  = (state_q == ST_EXEC);
    assign nbytes   = size_bytes(size_q);
    assign widx     = addr_q[5:2];
    assign wmask    = spread_word(wdata_q, widx);
    assign word_wr  = in_exec && write_q && !fault && (size_q == 2'b10);
    assign prio_off = addr_q - PRIO_BASE;
    assign sys_off  = addr_q - SYS_BASE;
    assign prio_we  = in_exec && write_q && !fault && (region == RG_PRIO);
    assign sys_we   = in_exec && write_q && !fault && (region == RG_SYSPRIO);

    irq_regwin_prio_bank #(.N(NUM_IRQ)) u_irq_prio (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (prio_we),
        .start     (prio_off[START_W-1:0]),
        .nbytes    (nbytes),
        .wdata     (wdata_q),
        .rdata     (prio_rd),
        .prio_flat (irq_prio)
    );

    irq_regwin_prio_bank #(.N(SYS_N)) u_sys_prio (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (sys_we),
        .start     (sys_off[START_W-1:0]),
        .nbytes    (nbytes),
        .wdata     (wdata_q),
        .rdata     (sys_rd),
        .prio_flat (sys_prio)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: ACCEPT, APPLY, RETIRE.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_EXEC;
            ST_EXEC: state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Request capture on ACCEPT.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            size_q  <= '0;
            write_q <= 1'b0;
            user_q  <= 1'b0;
            wdata_q <= '0;
        end else if (state_q == ST_IDLE && req_valid) begin
            addr_q  <= req_addr;
            size_q  <= req_size;
            write_q <= req_write;
            user_q  <= req_user;
            wdata_q <= req_wdata;
        end
    end

    // Next values of the bit registers in EXEC.
    always_comb begin
        en_d        = en_q;
        pend_d      = pend_q;
        ctrl_trig_d = ctrl_trig_q;
        if (word_wr) begin
            unique case (region)
                RG_SETEN: en_d   = en_q | wmask;
                RG_CLREN: en_d   = en_q & ~wmask;
                RG_SETPD: pend_d = pend_q | wmask;
                RG_CLRPD: pend_d = pend_q & ~wmask;
                RG_CTRL:  ctrl_trig_d = wdata_q[1];
                RG_TRIG: begin
                    for (int k = 0; k < NUM_IRQ; k++)
                        if (int'(wdata_q[8:0]) == k) pend_d[k] = 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Response data in EXEC.
    always_comb begin
        err_d   = fault;
        rdata_d = '0;
        if (!fault && !write_q) begin
            unique case (region)
                RG_SETEN, RG_CLREN: rdata_d = pick_word(en_q, widx);
                RG_SETPD, RG_CLRPD: rdata_d = pick_word(pend_q, widx);
                RG_ACTIVE:          rdata_d = pick_word(active_in, widx);
                RG_PRIO:            rdata_d = prio_rd;
                RG_SYSPRIO:         rdata_d = sys_rd;
                RG_CTRL:            rdata_d = {30'b0, ctrl_trig_q, 1'b0};
                default:            rdata_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q        <= '0;
            pend_q      <= '0;
            ctrl_trig_q <= 1'b0;
            rdata_q     <= '0;
            err_q       <= 1'b0;
        end else if (in_exec) begin
            en_q        <= en_d;
            pend_q      <= pend_d;
            ctrl_trig_q <= ctrl_trig_d;
            rdata_q     <= rdata_d;
            err_q       <= err_d;
        end
    end

    // Outputs.
    always_comb begin
        req_ready   = (state_q == ST_IDLE);
        rsp_valid   = (state_q == ST_RESP);
        rsp_err     = err_q;
        rsp_rdata   = rdata_q;
        irq_enable  = en_q;
        irq_pending = pend_q;
    end

    AST_FAULT_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_exec && fault) |=> ($stable(en_q) && $stable(pend_q) && $stable(ctrl_trig_q))); // R1
    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_rdata == '0)); // R1
    AST_USER_OUTSIDE_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && user_q && addr_q != TRIG_ADDR) |-> rsp_err); // R1
    AST_PEND_EXEC_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !in_exec |=> $stable(pend_q)); // R5
    AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R11
    AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> ##1 rsp_valid); // R11
endmodule

// File: tb/irq_regwin_bench.sv
module irq_regwin_bench;
    localparam int NUM_IRQ = 62;
    localparam int NV      = 45;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 req_valid = 1'b0;
    logic                 req_ready;
    logic [11:0]          req_addr = '0;
    logic [1:0]           req_size = '0;
    logic                 req_write = 1'b0;
    logic [31:0]          req_wdata = '0;
    logic                 req_user = 1'b0;
    logic                 rsp_valid, rsp_err;
    logic [31:0]          rsp_rdata;
    logic [NUM_IRQ-1:0]   active_in = 62'h3000_0000_8000_0001;
    logic [NUM_IRQ-1:0]   irq_enable, irq_pending;
    logic [NUM_IRQ*8-1:0] irq_prio;
    logic [95:0]          sys_prio;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    irq_regwin #(.NUM_IRQ(NUM_IRQ)) u_irq_regwin (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
        .req_user(req_user), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .active_in(active_in), .irq_enable(irq_enable),
        .irq_pending(irq_pending), .irq_prio(irq_prio), .sys_prio(sys_prio)
    );

    // {user, write, size, addr, wdata, exp_err, exp_rdata, req}
    localparam logic [84:0] VEC [NV] = '{
        {1'b0,1'b1,2'd2,12'h100,32'hFFFF_0003,1'b0,32'h0000_0000,4'd4},  // R4 set enables
        {1'b0,1'b0,2'd2,12'h100,32'h0,        1'b0,32'hFFFF_0003,4'd4},  // R4
        {1'b0,1'b1,2'd2,12'h104,32'hFFFF_FFFF,1'b0,32'h0000_0000,4'd10}, // R10 bits 62,63 absent
        {1'b0,1'b0,2'd2,12'h184,32'h0,        1'b0,32'h3FFF_FFFF,4'd10}, // R10 clear view read
        {1'b0,1'b1,2'd2,12'h180,32'h0000_0001,1'b0,32'h0000_0000,4'd4},  // R4 clear bit 0
        {1'b0,1'b0,2'd2,12'h100,32'h0,        1'b0,32'hFFFF_0002,4'd4},  // R4
        {1'b0,1'b1,2'd0,12'h180,32'hFFFF_FFFF,1'b0,32'h0000_0000,4'd9},  // R9 byte write ignored
        {1'b0,1'b0,2'd2,12'h100,32'h0,        1'b0,32'hFFFF_0002,4'd9},  // R9
        {1'b1,1'b0,2'd2,12'h100,32'h0,        1'b1,32'h0000_0000,4'd1},  // R1 user read
        {1'b1,1'b1,2'd2,12'h180,32'hFFFF_FFFF,1'b1,32'h0000_0000,4'd1},  // R1 user write
        {1'b0,1'b0,2'd2,12'h100,32'h0,        1'b0,32'hFFFF_0002,4'd1},  // R1 untouched
        {1'b1,1'b1,2'd2,12'hF00,32'h0000_0005,1'b1,32'h0000_0000,4'd2},  // R2 grant off
        {1'b0,1'b0,2'd2,12'h200,32'h0,        1'b0,32'h0000_0000,4'd2},  // R2 nothing pended
        {1'b0,1'b1,2'd2,12'hD14,32'h0000_0002,1'b0,32'h0000_0000,4'd2},  // R2 grant on
        {1'b0,1'b0,2'd2,12'hD14,32'h0,        1'b0,32'h0000_0002,4'd2},  // R2
        {1'b1,1'b1,2'd2,12'hF00,32'h0000_0005,1'b0,32'h0000_0000,4'd2},  // R2 user trigger ok
        {1'b1,1'b0,2'd2,12'hF00,32'h0,        1'b0,32'h0000_0000,4'd2},  // R2 user read 0
        {1'b0,1'b1,2'd2,12'hF00,32'h0000_003D,1'b0,32'h0000_0000,4'd3},  // R3 n=61
        {1'b0,1'b1,2'd2,12'hF00,32'h0000_003E,1'b0,32'h0000_0000,4'd3},  // R3 n=62 ignored
        {1'b0,1'b1,2'd2,12'hF00,32'hFFFF_FE20,1'b0,32'h0000_0000,4'd3},  // R3 n=32
        {1'b0,1'b0,2'd2,12'h200,32'h0,        1'b0,32'h0000_0020,4'd3},  // R3
        {1'b0,1'b0,2'd2,12'h204,32'h0,        1'b0,32'h2000_0001,4'd3},  // R3
        {1'b0,1'b1,2'd2,12'h200,32'h0000_0100,1'b0,32'h0000_0000,4'd5},  // R5 set 8
        {1'b0,1'b1,2'd2,12'h280,32'h0000_0020,1'b0,32'h0000_0000,4'd5},  // R5 clear 5
        {1'b0,1'b0,2'd2,12'h280,32'h0,        1'b0,32'h0000_0100,4'd5},  // R5
        {1'b0,1'b0,2'd2,12'h300,32'h0,        1'b0,32'h8000_0001,4'd6},  // R6
        {1'b0,1'b1,2'd2,12'h300,32'hFFFF_FFFF,1'b0,32'h0000_0000,4'd6},  // R6 write ok
        {1'b0,1'b0,2'd2,12'h304,32'h0,        1'b0,32'h3000_0000,4'd6},  // R6
        {1'b0,1'b1,2'd2,12'h400,32'h4433_2211,1'b0,32'h0000_0000,4'd7},  // R7 word
        {1'b0,1'b0,2'd0,12'h401,32'h0,        1'b0,32'h0000_0022,4'd7},  // R7 byte read
        {1'b0,1'b1,2'd1,12'h402,32'hAAAA_BBCC,1'b0,32'h0000_0000,4'd7},  // R7 half write
        {1'b0,1'b0,2'd2,12'h400,32'h0,        1'b0,32'hBBCC_2211,4'd7},  // R7
        {1'b0,1'b1,2'd2,12'h43C,32'h8877_6655,1'b0,32'h0000_0000,4'd10}, // R10 straddle
        {1'b0,1'b0,2'd2,12'h43C,32'h0,        1'b0,32'h0000_6655,4'd10}, // R10
        {1'b0,1'b1,2'd2,12'hD20,32'h0403_0201,1'b0,32'h0000_0000,4'd8},  // R8
        {1'b0,1'b1,2'd2,12'hD22,32'hF0E0_D0C0,1'b0,32'h0000_0000,4'd8},  // R8 straddle
        {1'b0,1'b0,2'd2,12'hD20,32'h0,        1'b0,32'hD0C0_0201,4'd8},  // R8
        {1'b0,1'b0,2'd0,12'hD18,32'h0,        1'b0,32'h0000_0000,4'd8},  // R8
        {1'b0,1'b1,2'd2,12'h800,32'h0000_FFFF,1'b0,32'h0000_0000,4'd10}, // R10 unmapped
        {1'b0,1'b0,2'd2,12'h800,32'h0,        1'b0,32'h0000_0000,4'd10}, // R10
        {1'b1,1'b0,2'd2,12'hD14,32'h0,        1'b1,32'h0000_0000,4'd1},  // R1
        {1'b1,1'b1,2'd2,12'h400,32'h0000_00FF,1'b1,32'h0000_0000,4'd1},  // R1
        {1'b0,1'b0,2'd2,12'h400,32'h0,        1'b0,32'hBBCC_2211,4'd1},  // R1 untouched
        {1'b0,1'b1,2'd0,12'hF00,32'h0000_0009,1'b0,32'h0000_0000,4'd9},  // R9 byte trigger
        {1'b0,1'b0,2'd2,12'h200,32'h0,        1'b0,32'h0000_0100,4'd9}   // R9
    };

    task automatic check(input bit ok, input int req, input logic [95:0] act,
                         input logic [95:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic access(input logic user, input logic wr, input logic [1:0] sz,
                          input logic [11:0] addr, input logic [31:0] wd,
                          output logic err, output logic [31:0] rd);
        @(negedge clk);
        req_valid = 1'b1; req_user = user; req_write = wr;
        req_size = sz; req_addr = addr; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        check(!rsp_valid && !req_ready, 11, {94'b0, rsp_valid, req_ready}, 96'h0); // R11
        @(negedge clk);
        check(rsp_valid === 1'b1, 11, {95'b0, rsp_valid}, 96'h1);                  // R11
        err = rsp_err; rd = rsp_rdata;
        @(negedge clk);
        check(!rsp_valid && req_ready, 11, {94'b0, rsp_valid, req_ready}, 96'h1);  // R11
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic        e;
        logic [31:0] d;
        repeat (3) @(negedge clk);
        // R12 reset state
        check(req_ready && !rsp_valid && irq_enable == '0 && irq_pending == '0
              && irq_prio == '0 && sys_prio == '0, 12,
              {94'b0, req_ready, rsp_valid}, 96'h2);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            access(VEC[v][84], VEC[v][83], VEC[v][82:81], VEC[v][80:69],
                   VEC[v][68:37], e, d);
            check(e === VEC[v][36] && d === VEC[v][35:4], int'(VEC[v][3:0]),
                  {63'b0, e, d}, {63'b0, VEC[v][36:4]});
        end

        // Port views of the state built above.
        check(irq_enable[31:0] == 32'hFFFF_0002, 4, {64'b0, irq_enable[31:0]}, 96'hFFFF_0002); // R4
        check(irq_prio[2*8 +: 8] == 8'hCC && irq_prio[61*8 +: 8] == 8'h66, 7,
              {80'b0, irq_prio[2*8 +: 8], irq_prio[61*8 +: 8]}, 96'hCC66);                 // R7
        check(sys_prio[10*8 +: 8] == 8'hC0 && sys_prio[11*8 +: 8] == 8'hD0, 8,
              {80'b0, sys_prio[11*8 +: 8], sys_prio[10*8 +: 8]}, 96'hD0C0);                // R8

        // R12 reset mid-run clears all state.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        access(1'b0, 1'b0, 2'd2, 12'h100, 32'h0, e, d);
        check(d == 32'h0 && irq_pending == '0 && irq_prio == '0, 12, {64'b0, d}, 96'h0);
        access(1'b0, 1'b0, 2'd2, 12'hD14, 32'h0, e, d);
        check(d == 32'h0 && !e, 12, {63'b0, e, d}, 96'h0);
        access(1'b1, 1'b1, 2'd2, 12'hF00, 32'h1, e, d);
        check(e == 1'b1 && irq_pending == '0, 2, {95'b0, e}, 96'h1);                       // R2

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule